// File: doc/BRIEF.md
# Address-Pattern Unlocked Partition Write Guard

This block sits between a host and a static RAM and splits the memory into sixteen equal partitions, each chosen by the four upper address lines. A 16-bit protect mask selects which partitions refuse writes. While a write strobe is aimed at a protected partition, the gated write-enable stays high. Writes to partitions that are not protected pass through unchanged.

The mask has no register interface. It is programmed through the address lines alone. Twenty consecutive read cycles must present a fixed sequence of upper-address nibbles. The next four read cycles then each supply four mask bits. Any write cycle during this process sends the matcher back to the start. A read that breaks the sequence also restarts it. A mask bit of 1 protects its partition and 0 leaves it writable. The mask register has no reset, so its contents persist across host resets. Its value before the first load is undefined.

A strap input enables the whole guard. The strap value is tracked while the supply is good and held while the supply-fail flag is raised, so the configuration is kept through a power loss. With the guard disabled, addresses and host writes are not acted on, and the output-enable that drives the write-enable and fail outputs is low.

Top module: `pf_wr_guard`

## Requirements
- R1: After reset the latched enable is 0, so out_en_o is 0 and we_no equals we_ni.
- R2: A read cycle is CE_n low with WE_n high for the whole cycle, and it is taken when CE_n rises, using the nibble {Az,Ay,Ax,Aw} (bit 0 = Aw) present in its last low clock. Twenty reads in a row carrying the nibbles F,E,7,7,3,9,C,E,7,3,9,4,2,4,A,6,9,1,0,5 (hex) unlock mask loading.
- R3: After unlock, load read k (k = 0..3) writes its nibble into mask bits 4k..4k+3, with address bit i going to mask bit 4k+i.
- R4: While enabled, we_no is 1 whenever mask[addr_hi_i] is 1; otherwise we_no equals we_ni. A host we_ni of 1 always gives we_no = 1.
- R5: A write cycle (WE_n low at any clock while CE_n is low) restarts matching at step 1, and the mask does not change.
- R6: A read whose nibble differs from the expected step restarts matching; if that nibble is F it counts as step 1 of a new attempt.
- R7: After the fourth load read the matcher returns to idle, so further reads do not change the mask until a new full sequence is sent.
- R8: While the latched enable is 0, out_en_o is 0, we_no equals we_ni for every address, and reads do not advance matching or change the mask.
- R9: While supply_fail_i is 0, the latched enable follows dis_strap_i with one clock of delay. While supply_fail_i is 1, it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (the mask is not reset) |
| addr_hi_i | input | 4 | Upper RAM address nibble {Az,Ay,Ax,Aw} |
| ce_ni | input | 1 | Host chip enable, active low |
| we_ni | input | 1 | Host write enable, active low |
| dis_strap_i | input | 1 | Guard enable strap; 1 turns partition protection on |
| supply_fail_i | input | 1 | Supply out-of-tolerance flag; 1 holds the strap latch |
| we_no | output | 1 | Gated write enable to RAM, active low |
| out_en_o | output | 1 | Drive enable for the write-enable and fail outputs |

## Verification
The mask is programmed with asymmetric values: A5C3, then 0FF0, then 5A5A. Each value is read back by probing writes to all sixteen partitions, which exposes swapped slots, reversed bit order inside a slot, and an off-by-one partition decode. Three faulty programming attempts are then tried. The first is a sequence broken by a write halfway through. The second is a sequence broken by an extra F, which must count as a new step 1. The third is a valid load followed by four stray reads. These attempts tell correct restart behaviour apart from a matcher that ignores writes, drops the F, or keeps loading past the fourth slot. A load sent with the strap low, and a strap change made while the supply is failing, check that the enable latch and the disable path guard the mask.

// File: rtl/pf_wr_guard_pkg.sv
package pf_wr_guard_pkg;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned NPART    = 1 << NIB_W;
  localparam int unsigned SEQ_LEN  = 20;
  localparam int unsigned LOAD_LEN = NPART / NIB_W;
  localparam int unsigned CNT_W    = $clog2(SEQ_LEN);
  localparam int unsigned SLOT_W   = $clog2(LOAD_LEN);

  typedef enum logic {PH_MATCH, PH_LOAD} phase_e;

  function automatic logic [NIB_W-1:0] key_nib(input logic [CNT_W-1:0] idx);
    case (idx)
      5'd0:  key_nib = 4'hF;
      5'd1:  key_nib = 4'hE;
      5'd2:  key_nib = 4'h7;
      5'd3:  key_nib = 4'h7;
      5'd4:  key_nib = 4'h3;
      5'd5:  key_nib = 4'h9;
      5'd6:  key_nib = 4'hC;
      5'd7:  key_nib = 4'hE;
      5'd8:  key_nib = 4'h7;
      5'd9:  key_nib = 4'h3;
      5'd10: key_nib = 4'h9;
      5'd11: key_nib = 4'h4;
      5'd12: key_nib = 4'h2;
      5'd13: key_nib = 4'h4;
      5'd14: key_nib = 4'hA;
      5'd15: key_nib = 4'h6;
      5'd16: key_nib = 4'h9;
      5'd17: key_nib = 4'h1;
      5'd18: key_nib = 4'h0;
      5'd19: key_nib = 4'h5;
      default: key_nib = '0;
    endcase
  endfunction
endpackage

// File: rtl/pf_cyc_mon.sv
// Classifies host cycles; strobes fire one clock after CE_n rises.
module pf_cyc_mon
  import pf_wr_guard_pkg::*;
#(
  parameter int unsigned AW = NIB_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ce_ni,
  input  logic          we_ni,
  output logic          rd_stb_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] nib_o
);
  logic          ce_q;
  logic          wr_seen_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q      <= 1'b1;
      wr_seen_q <= 1'b0;
      addr_q    <= '0;
      rd_stb_o  <= 1'b0;
      wr_stb_o  <= 1'b0;
      nib_o     <= '0;
    end else begin
      ce_q     <= ce_ni;
      rd_stb_o <= 1'b0;
      wr_stb_o <= 1'b0;
      if (!ce_ni) begin
        addr_q    <= addr_i;
        wr_seen_q <= (ce_q ? 1'b0 : wr_seen_q) | ~we_ni;
      end
      if (!ce_q && ce_ni) begin
        rd_stb_o <= ~wr_seen_q;
        wr_stb_o <= wr_seen_q;
        nib_o    <= addr_q;
      end
    end
  end
endmodule

// File: rtl/pf_unlock_fsm.sv
module pf_unlock_fsm
  import pf_wr_guard_pkg::*;
#(
  parameter int unsigned AW = NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rd_stb_i,
  input  logic              wr_stb_i,
  input  logic [AW-1:0]     nib_i,
  output phase_e            phase_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ld_o,
  output logic [SLOT_W-1:0] ld_slot_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_MATCH;
      cnt_q   <= '0;
    end else if (!en_i || wr_stb_i) begin
      phase_q <= PH_MATCH;
      cnt_q   <= '0;
    end else if (rd_stb_i) begin
      if (phase_q == PH_MATCH) begin
        if (nib_i == key_nib(cnt_q)) begin
          if (cnt_q == CNT_W'(SEQ_LEN - 1)) begin
            phase_q <= PH_LOAD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else begin
          // a broken step may itself open a new attempt
          cnt_q <= (nib_i == key_nib('0)) ? CNT_W'(1) : '0;
        end
      end else begin
        if (cnt_q == CNT_W'(LOAD_LEN - 1)) begin
          phase_q <= PH_MATCH;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign phase_o   = phase_q;
  assign cnt_o     = cnt_q;
  assign ld_o      = en_i & rd_stb_i & (phase_q == PH_LOAD);
  assign ld_slot_o = cnt_q[SLOT_W-1:0];
endmodule

// File: rtl/pf_mask_reg.sv
// No reset: contents model battery-held state.
module pf_mask_reg
  import pf_wr_guard_pkg::*;
#(
  parameter int unsigned AW = NIB_W,
  localparam int unsigned NP = 1 << AW,
  localparam int unsigned NS = NP / AW,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic          clk_i,
  input  logic          ld_i,
  input  logic [SW-1:0] slot_i,
  input  logic [AW-1:0] nib_i,
  input  logic [AW-1:0] addr_i,
  output logic [NP-1:0] mask_o,
  output logic          prot_o
);
  logic [NP-1:0] mask_q;

  for (genvar g = 0; g < NS; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (ld_i && (slot_i == SW'(g))) mask_q[g*AW +: AW] <= nib_i;
    end
  end

  assign mask_o = mask_q;
  assign prot_o = mask_q[addr_i];
endmodule

// File: rtl/pf_wr_guard.sv
module pf_wr_guard
  import pf_wr_guard_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIB_W-1:0] addr_hi_i,
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic             dis_strap_i,
  input  logic             supply_fail_i,
  output logic             we_no,
  output logic             out_en_o
);
  logic              en_q;
  logic              rd_stb;
  logic              wr_stb;
  logic [NIB_W-1:0]  nib;
  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic              ld;
  logic [SLOT_W-1:0] ld_slot;
  logic [NPART-1:0]  mask_q;
  logic              prot;

  // strap tracked while supply good, frozen while failing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             en_q <= 1'b0;
    else if (!supply_fail_i) en_q <= dis_strap_i;
  end

  pf_cyc_mon #(.AW(NIB_W)) u_cyc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_hi_i),
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .rd_stb_o (rd_stb),
    .wr_stb_o (wr_stb),
    .nib_o    (nib)
  );

  pf_unlock_fsm #(.AW(NIB_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .rd_stb_i  (rd_stb),
    .wr_stb_i  (wr_stb),
    .nib_i     (nib),
    .phase_o   (phase),
    .cnt_o     (cnt),
    .ld_o      (ld),
    .ld_slot_o (ld_slot)
  );

  pf_mask_reg #(.AW(NIB_W)) u_mask (
    .clk_i  (clk_i),
    .ld_i   (ld),
    .slot_i (ld_slot),
    .nib_i  (nib),
    .addr_i (addr_hi_i),
    .mask_o (mask_q),
    .prot_o (prot)
  );

  assign we_no    = we_ni | (en_q & prot);
  assign out_en_o = en_q;
endmodule

// File: rtl/pf_wr_guard_chk.sv
module pf_wr_guard_chk
  import pf_wr_guard_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NIB_W-1:0] addr_hi_i,
  input logic             we_ni,
  input logic             supply_fail_i,
  input logic             we_no,
  input logic             out_en_o,
  input logic [NPART-1:0] mask_q,
  input logic             wr_stb,
  input phase_e           phase,
  input logic [CNT_W-1:0] cnt
);
  AST_HOST_HIGH_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_ni |-> we_no); // R4
  AST_PROT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_o && mask_q[addr_hi_i]) |-> we_no); // R4
  AST_DIS_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_o |-> (we_no == we_ni)); // R8
  AST_STRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_fail_i |=> $stable(out_en_o)); // R9
  AST_WRITE_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |=> (phase == PH_MATCH && cnt == '0)); // R5
  AST_LOAD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase == PH_LOAD) |-> ($past(cnt) == CNT_W'(SEQ_LEN - 1))); // R2
  AST_LOAD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_LOAD) |-> (cnt < CNT_W'(LOAD_LEN))); // R7
  AST_MATCH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_MATCH) |-> (cnt < CNT_W'(SEQ_LEN))); // R2
endmodule

bind pf_wr_guard pf_wr_guard_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_hi_i     (addr_hi_i),
  .we_ni         (we_ni),
  .supply_fail_i (supply_fail_i),
  .we_no         (we_no),
  .out_en_o      (out_en_o),
  .mask_q        (mask_q),
  .wr_stb        (wr_stb),
  .phase         (phase),
  .cnt           (cnt)
);

// File: tb/pf_wr_guard_tb_top.sv
module pf_wr_guard_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_hi_i = 4'h0;
  logic       ce_ni = 1'b1;
  logic       we_ni = 1'b1;
  logic       dis_strap_i = 1'b0;
  logic       supply_fail_i = 1'b0;
  logic       we_no;
  logic       out_en_o;

  always #5 clk_i = ~clk_i;

  pf_wr_guard dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_hi_i(addr_hi_i), .ce_ni(ce_ni),
    .we_ni(we_ni), .dis_strap_i(dis_strap_i), .supply_fail_i(supply_fail_i),
    .we_no(we_no), .out_en_o(out_en_o)
  );

  typedef struct {logic exp_we; logic exp_oe; string tag;} item_t;
  item_t q[$];
  event  probe_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  localparam logic [3:0] KEY [20] = '{4'hF, 4'hE, 4'h7, 4'h7, 4'h3, 4'h9, 4'hC,
    4'hE, 4'h7, 4'h3, 4'h9, 4'h4, 4'h2, 4'h4, 4'hA, 4'h6, 4'h9, 4'h1, 4'h0, 4'h5};

  // monitor: pops expectations as probes land
  initial begin
    forever begin
      @(probe_ev);
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (we_no !== it.exp_we || out_en_o !== it.exp_oe) begin
          n_fail++;
          $display("FAIL %s: we_no=%b out_en_o=%b expected we_no=%b out_en_o=%b",
                   it.tag, we_no, out_en_o, it.exp_we, it.exp_oe);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic rd(input logic [3:0] nib);
    @(negedge clk_i); addr_hi_i = nib; ce_ni = 1'b0; we_ni = 1'b1;
    idle(2); ce_ni = 1'b1;
    idle(2);
  endtask

  task automatic wr(input logic [3:0] nib);
    @(negedge clk_i); addr_hi_i = nib; ce_ni = 1'b0; we_ni = 1'b0;
    @(negedge clk_i); we_ni = 1'b1;
    @(negedge clk_i); ce_ni = 1'b1;
    idle(2);
  endtask

  // driver: starts a cycle, pushes the expectation, fires the monitor
  task automatic probe(input logic [3:0] nib, input logic host_we,
                       input logic exp_we, input logic exp_oe, input string tag);
    @(negedge clk_i); addr_hi_i = nib; ce_ni = 1'b0; we_ni = host_we;
    q.push_back('{exp_we: exp_we, exp_oe: exp_oe, tag: tag});
    #1 -> probe_ev;
    @(negedge clk_i); we_ni = 1'b1;
    @(negedge clk_i); ce_ni = 1'b1;
    idle(2);
  endtask

  task automatic unlock();
    for (int i = 0; i < 20; i++) rd(KEY[i]);
  endtask

  task automatic load(input logic [15:0] m);
    for (int k = 0; k < 4; k++) rd(m[4*k +: 4]);
  endtask

  task automatic probe_all(input logic [15:0] m, input string tag);
    for (int p = 0; p < 16; p++) probe(4'(p), 1'b0, m[p], 1'b1, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    // R1: reset state, guard off
    probe(4'h3, 1'b0, 1'b0, 1'b0, "R1 reset we pass");
    probe(4'h3, 1'b1, 1'b1, 1'b0, "R1 reset we high");

    dis_strap_i = 1'b1;
    idle(3);

    // R2 R3 R4: full unlock then load A5C3
    unlock();
    load(16'hA5C3);
    probe_all(16'hA5C3, "R2 R3 R4 mask A5C3");
    probe(4'h0, 1'b1, 1'b1, 1'b1, "R4 host high on protected");
    probe(4'h2, 1'b0, 1'b0, 1'b1, "R4 host low on writable");

    // R5: write halfway aborts
    for (int i = 0; i < 10; i++) rd(KEY[i]);
    wr(4'h8);
    for (int i = 10; i < 20; i++) rd(KEY[i]);
    load(16'h1234);
    probe_all(16'hA5C3, "R5 write abort");

    // R6: stray F restarts at step 1
    rd(4'hF); rd(4'hE); rd(4'h7);
    for (int i = 0; i < 20; i++) rd(KEY[i]);
    load(16'h0FF0);
    probe_all(16'h0FF0, "R6 F restart");

    // R7: reads after the fourth load are ignored
    unlock();
    load(16'h5A5A);
    for (int i = 0; i < 4; i++) rd(4'h0);
    probe_all(16'h5A5A, "R7 idle after load");

    // R8: disabled guard is transparent and ignores a load
    dis_strap_i = 1'b0;
    idle(3);
    probe(4'h1, 1'b0, 1'b0, 1'b0, "R8 disabled pass");
    probe(4'h1, 1'b1, 1'b1, 1'b0, "R8 disabled high");
    unlock();
    load(16'hFFFF);
    dis_strap_i = 1'b1;
    idle(3);
    probe_all(16'h5A5A, "R8 no load while disabled");

    // R9: strap held during supply fail
    supply_fail_i = 1'b1;
    idle(2);
    dis_strap_i = 1'b0;
    idle(3);
    probe(4'h1, 1'b0, 1'b1, 1'b1, "R9 held during fail");
    supply_fail_i = 1'b0;
    idle(3);
    probe(4'h1, 1'b0, 1'b0, 1'b0, "R9 follows after fail");

    idle(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule